// File: doc/BRIEF.md
# Multichannel TDM serial port

This block is a full-duplex time-division-multiplexed serial port for a telephony backplane. A frame holds 128 time slots of 8 bits each, 1024 bit clocks in all. Transmit words enter through a valid/ready interface and are shifted out on a serial data pin. Receive words are assembled from the serial input pin and handed out with the number of the slot they came from. One 128-bit enable map per direction selects which slots the port drives and which it captures. Each map is written as eight 16-bit registers.

The bit clock and the active-low frame sync come from the backplane. Both are sampled by the block's system clock, which must run fast enough that each half of the bit clock lasts at least three system clock cycles. The frame sync is sampled on a falling bit-clock edge, half a bit ahead of the first data bit. Slot 0 begins on the very next rising edge, with no bit of delay. Both directions share that frame position. The map registers are written while a direction is disabled, and the direction is then enabled. The port passes raw bytes only.

Top module: `tdm_slot_port`

## Requirements
- R1: After `fsync_n` is seen low on a falling edge of `bclk`, the next rising edge starts bit 0 of slot 0. Slot s then occupies frame bits 8s to 8s+7, counted in rising edges.
- R2: Words are sent and received most significant bit first. `dt` changes only after a rising edge of `bclk`, and `dr` is sampled on the falling edge that follows.
- R3: Bit s%16 of map register s/16 enables slot s. The map is selected by `cfg_dir` (0 = transmit, 1 = receive) and the register by `cfg_idx`, and the data is written on `cfg_wr`. Both maps are all zero after reset, so no slot is driven or captured.
- R4: `dt_oe` is low throughout a slot whose transmit enable is clear, and whenever `tx_en` is low. `tx_ready` is low while `tx_en` is low.
- R5: A word received in an enabled receive slot appears on `rx_data` with its slot number on `rx_slot`. `rx_valid` stays high until the word is taken with `rx_ready`. Words from disabled slots are discarded.
- R6: When an enabled transmit slot begins with no word waiting, the slot sends 0x00 and `tx_underflow` sets. The flag stays set until reset.
- R7: When a receive word completes while the previous word is still untaken, the new word replaces the old one and `rx_overflow` sets. The flag stays set until reset.
- R8: A map write to the transmit map while `tx_en` is high has no effect. A map write to the receive map while `rx_en` is high has no effect.
- R9: The frame sync is needed for every frame. If none arrives before the end of bit 1023, the port stops driving and capturing until the next frame sync, and then resumes at slot 0.
- R10: With `dt` tied to `dr`, each slot that is enabled in both maps receives the word that was sent in that slot.
- R11: During and after reset, `dt_oe`, `rx_valid`, `tx_ready`, `tx_underflow` and `rx_overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Backplane bit clock, sampled by clk |
| fsync_n | input | 1 | Active-low frame sync |
| dr | input | 1 | Serial receive data |
| dt | output | 1 | Serial transmit data |
| dt_oe | output | 1 | Drive enable for dt |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| cfg_wr | input | 1 | Map register write strobe |
| cfg_dir | input | 1 | Map select: 0 transmit, 1 receive |
| cfg_idx | input | 3 | Map register number |
| cfg_data | input | 16 | Map register value |
| tx_data | input | 8 | Transmit word |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word accepted when valid |
| rx_data | output | 8 | Received word |
| rx_valid | output | 1 | Received word pending |
| rx_ready | input | 1 | Received word taken |
| rx_slot | output | 7 | Slot number of the received word |
| tx_underflow | output | 1 | Sticky transmit underflow |
| rx_overflow | output | 1 | Sticky receive overflow |

## Verification
A frame position that is off by even one bit would move every word across a slot boundary. In loopback, that shows up on the very first received word as a wrong byte or a wrong `rx_slot` value. A corrupted map bit shows at the ports within one slot time: `dt_oe` is wrong at that slot's first bit, or a word appears for the wrong slot or fails to appear. A stuck word holder or a lost frame-sync state shows within one frame, as an unexpected underflow, a missing word count, or `dt_oe` still high after a frame that had no sync.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
    typedef enum logic {
        CFG_TX = 1'b0,
        CFG_RX = 1'b1
    } cfg_bank_e;
endpackage

// File: rtl/tdm_frame_timer.sv
// Tracks the bit position within a frame; the sync is sampled on a falling edge
// and the frame starts on the following rising edge.
module tdm_frame_timer #(
    parameter int FRAME_BITS = 1024,
    parameter int POS_W      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             fall,
    input  logic             fsync_n,
    output logic [POS_W-1:0] pos,
    output logic             framed,
    output logic             bit_go
);
    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic             armed;
        logic             framed;
        logic             go;
        logic [POS_W-1:0] pos;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.go = 1'b0;
        if (fall && !fsync_n) begin
            st_d.armed = 1'b1;
        end
        if (rise) begin
            st_d.go = 1'b1;
            if (st_q.armed) begin
                st_d.armed  = 1'b0;
                st_d.framed = 1'b1;
                st_d.pos    = '0;
            end else if (st_q.framed) begin
                if (st_q.pos == LAST) begin
                    st_d.framed = 1'b0;
                end else begin
                    st_d.pos = st_q.pos + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos    = st_q.pos;
    assign framed = st_q.framed;
    assign bit_go = st_q.go;
endmodule

// File: rtl/tdm_chan_map.sv
// One direction's slot-enable bitmap, written as REG_W-bit registers.
module tdm_chan_map #(
    parameter int SLOTS = 128,
    parameter int REG_W = 16,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             lock,
    input  logic [IDX_W-1:0] idx,
    input  logic [REG_W-1:0] data,
    output logic [SLOTS-1:0] map
);
    logic [SLOTS-1:0] map_d, map_q;

    always_comb begin
        map_d = map_q;
        if (wr && !lock) begin
            map_d[idx*REG_W +: REG_W] = data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else begin
            map_q <= map_d;
        end
    end

    assign map = map_q;
endmodule

// File: rtl/tdm_tx_lane.sv
// One-word holder plus shifter; loads at each slot start, MSB first.
module tdm_tx_lane #(
    parameter int WORD_W = 8,
    parameter int BIT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              bit_go,
    input  logic              framed,
    input  logic [BIT_W-1:0]  pos_bit,
    input  logic              slot_on,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              dt,
    output logic              dt_oe,
    output logic              underflow
);
    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] hold;
        logic              full;
        logic              oe;
        logic              uf;
    } st_t;

    st_t st_d, st_q;

    assign tx_ready = en && !st_q.full;

    always_comb begin
        st_d = st_q;
        if (bit_go) begin
            if (!framed || !en) begin
                st_d.oe = 1'b0;
            end else if (pos_bit == '0) begin
                st_d.oe = slot_on;
                if (slot_on) begin
                    if (st_q.full) begin
                        st_d.sh   = st_q.hold;
                        st_d.full = 1'b0;
                    end else begin
                        st_d.sh = '0;
                        st_d.uf = 1'b1;
                    end
                end
            end else begin
                st_d.sh = {st_q.sh[WORD_W-2:0], 1'b0};
            end
        end
        if (tx_valid && tx_ready) begin
            st_d.hold = tx_data;
            st_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dt        = st_q.sh[WORD_W-1];
    assign dt_oe     = st_q.oe && en;
    assign underflow = st_q.uf;
endmodule

// File: rtl/tdm_rx_lane.sv
// Shifts in on falling edges; presents a finished word from an enabled slot.
module tdm_rx_lane #(
    parameter int WORD_W = 8,
    parameter int BIT_W  = 3,
    parameter int SLOT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              fall,
    input  logic              framed,
    input  logic [BIT_W-1:0]  pos_bit,
    input  logic [SLOT_W-1:0] pos_slot,
    input  logic              slot_on,
    input  logic              dr,
    input  logic              rx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic [SLOT_W-1:0] rx_slot,
    output logic              overflow
);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] data;
        logic [SLOT_W-1:0] slot;
        logic              valid;
        logic              ov;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.valid && rx_ready) begin
            st_d.valid = 1'b0;
        end
        if (fall && framed && en) begin
            st_d.sh = {st_q.sh[WORD_W-2:0], dr};
            if (pos_bit == BIT_LAST && slot_on) begin
                st_d.data  = {st_q.sh[WORD_W-2:0], dr};
                st_d.slot  = pos_slot;
                st_d.valid = 1'b1;
                if (st_q.valid && !rx_ready) begin
                    st_d.ov = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_data  = st_q.data;
    assign rx_valid = st_q.valid;
    assign rx_slot  = st_q.slot;
    assign overflow = st_q.ov;
endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port #(
    parameter int WORD_W = 8,
    parameter int SLOTS  = 128,
    parameter int REG_W  = 16,
    localparam int NREG   = SLOTS / REG_W,
    localparam int IDX_W  = $clog2(NREG),
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int BIT_W  = $clog2(WORD_W),
    localparam int FRAME_BITS = SLOTS * WORD_W,
    localparam int POS_W  = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk,
    input  logic              fsync_n,
    input  logic              dr,
    output logic              dt,
    output logic              dt_oe,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              cfg_wr,
    input  logic              cfg_dir,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [REG_W-1:0]  cfg_data,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [SLOT_W-1:0] rx_slot,
    output logic              tx_underflow,
    output logic              rx_overflow
);
    import tdm_pkg::*;

    logic bclk_d, bclk_q;
    logic rise, fall;
    logic [POS_W-1:0] pos;
    logic framed, bit_go;
    logic [SLOTS-1:0] tx_map, rx_map;
    logic [SLOT_W-1:0] pos_slot;
    logic [BIT_W-1:0]  pos_bit;

    always_comb begin
        bclk_d = bclk;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
        end else begin
            bclk_q <= bclk_d;
        end
    end

    assign rise     = bclk && !bclk_q;
    assign fall     = !bclk && bclk_q;
    assign pos_slot = pos[POS_W-1:BIT_W];
    assign pos_bit  = pos[BIT_W-1:0];

    tdm_frame_timer #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .fsync_n(fsync_n),
        .pos(pos), .framed(framed), .bit_go(bit_go)
    );

    tdm_chan_map #(.SLOTS(SLOTS), .REG_W(REG_W), .IDX_W(IDX_W)) u_tx_map (
        .clk(clk), .rst_n(rst_n),
        .wr(cfg_wr && (cfg_bank_e'(cfg_dir) == CFG_TX)), .lock(tx_en),
        .idx(cfg_idx), .data(cfg_data), .map(tx_map)
    );

    tdm_chan_map #(.SLOTS(SLOTS), .REG_W(REG_W), .IDX_W(IDX_W)) u_rx_map (
        .clk(clk), .rst_n(rst_n),
        .wr(cfg_wr && (cfg_bank_e'(cfg_dir) == CFG_RX)), .lock(rx_en),
        .idx(cfg_idx), .data(cfg_data), .map(rx_map)
    );

    tdm_tx_lane #(.WORD_W(WORD_W), .BIT_W(BIT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(tx_en), .bit_go(bit_go), .framed(framed),
        .pos_bit(pos_bit), .slot_on(tx_map[pos_slot]),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .dt(dt), .dt_oe(dt_oe), .underflow(tx_underflow)
    );

    tdm_rx_lane #(.WORD_W(WORD_W), .BIT_W(BIT_W), .SLOT_W(SLOT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .fall(fall), .framed(framed),
        .pos_bit(pos_bit), .pos_slot(pos_slot), .slot_on(rx_map[pos_slot]),
        .dr(dr), .rx_ready(rx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_slot(rx_slot),
        .overflow(rx_overflow)
    );
endmodule

// File: rtl/tdm_slot_port_chk.sv
module tdm_slot_port_chk #(
    parameter int SLOTS = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bclk,
    input logic             tx_en,
    input logic             rx_en,
    input logic             dt,
    input logic             dt_oe,
    input logic             rx_valid,
    input logic             rx_ready,
    input logic             tx_underflow,
    input logic             rx_overflow,
    input logic             framed,
    input logic [SLOTS-1:0] tx_map,
    input logic [SLOTS-1:0] rx_map
);
    // R6: underflow flag is sticky
    a_r6_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underflow |=> tx_underflow);

    // R7: overflow flag is sticky
    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overflow |=> rx_overflow);

    // R5: a pending word is held until taken
    a_r5_rx_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> rx_valid);

    // R9: no drive once the frame has lapsed
    a_r9_no_drive_unframed: assert property (@(posedge clk) disable iff (!rst_n)
        (!framed && $past(!framed)) |-> !dt_oe);

    // R2: driven data moves only during the high phase of the bit clock
    a_r2_dt_moves_high: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_oe && $past(dt_oe) && (dt != $past(dt))) |-> bclk);

    // R8: maps frozen while their direction is enabled
    a_r8_tx_map_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en)) |-> $stable(tx_map));

    a_r8_rx_map_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && $past(rx_en)) |-> $stable(rx_map));
endmodule

bind tdm_slot_port tdm_slot_port_chk #(.SLOTS(SLOTS)) i_chk (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .tx_en(tx_en), .rx_en(rx_en),
    .dt(dt), .dt_oe(dt_oe), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_underflow(tx_underflow), .rx_overflow(rx_overflow),
    .framed(framed), .tx_map(tx_map), .rx_map(rx_map)
);

// File: tb/test_tdm_slot_port.sv
module test_tdm_slot_port;
    localparam int CLK_PERIOD = 10;
    localparam int NSLOT = 128;
    localparam int FBITS = 1024;

    logic clk = 1'b0;
    logic rst_n, bclk, fsync_n, tx_en, rx_en, cfg_wr, cfg_dir, tx_valid, rx_ready;
    logic [2:0] cfg_idx;
    logic [15:0] cfg_data;
    logic [7:0] tx_data, rx_data;
    logic [6:0] rx_slot;
    logic dt, dt_oe, tx_ready, rx_valid, tx_underflow, rx_overflow;
    wire  dr;

    assign dr = dt_oe ? dt : 1'b1;   // loopback with pull-up

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_slot_port i_tdm_slot_port (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync_n(fsync_n), .dr(dr),
        .dt(dt), .dt_oe(dt_oe), .tx_en(tx_en), .rx_en(rx_en),
        .cfg_wr(cfg_wr), .cfg_dir(cfg_dir), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_slot(rx_slot), .tx_underflow(tx_underflow), .rx_overflow(rx_overflow)
    );

    int ntot = 0, nfail = 0;
    int src_k = 0, tx_k = 0, nwords = 0, ntx = 0;
    int exp_rs = 0, exp_fr = 0, last_d = -1, last_s = -1;
    bit src_on = 0, take = 0, sink_chk = 0;

    function automatic logic [15:0] txm(int i);
        return 16'hFFFF ^ (16'h0003 << (2*i));
    endfunction
    function automatic logic [15:0] rxm(int i);
        return (i == 7) ? 16'h00FF : 16'hFFFF;
    endfunction
    function automatic bit txon(int s);
        logic [15:0] r = txm(s/16);
        return r[s%16];
    endfunction
    function automatic bit rxon(int s);
        logic [15:0] r = rxm(s/16);
        return r[s%16];
    endfunction
    function automatic logic [7:0] wv(int k);
        return 8'((k*37 + 11) % 256);
    endfunction
    function automatic int before_tx(int s);
        int c = 0;
        for (int j = 0; j < s; j++) if (txon(j)) c++;
        return c;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        ntot++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // transmit source
    initial begin
        tx_valid = 1'b0;
        tx_data  = '0;
        forever begin
            @(negedge clk); #1;
            if (take) src_k++;
            tx_valid = src_on;
            tx_data  = wv(src_k);
            take     = tx_valid && tx_ready;
        end
    end

    // receive sink
    initial begin
        forever begin
            @(negedge clk); #1;
            if (rx_valid && rx_ready) begin
                nwords++;
                last_d = int'(rx_data);
                last_s = int'(rx_slot);
                if (sink_chk) begin
                    int e;
                    e = txon(exp_rs) ? int'(wv(exp_fr*ntx + before_tx(exp_rs))) : 8'hFF;
                    chk("R5 rx_slot order", int'(rx_slot), exp_rs);
                    chk("R10 loopback word", int'(rx_data), e);
                    do begin
                        exp_rs++;
                        if (exp_rs == NSLOT) begin exp_rs = 0; exp_fr++; end
                    end while (!rxon(exp_rs));
                end
            end
        end
    end

    task automatic cfg_write(input bit dir, input int idx, input logic [15:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dir = dir; cfg_idx = 3'(idx); cfg_data = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // mode 0: no line checks, 1: expect no drive, 2: full drive checks
    task automatic run_frames(input int n, input int mode);
        bclk = 1'b1; repeat (4) @(negedge clk);
        bclk = 1'b0; fsync_n = 1'b0; repeat (4) @(negedge clk); fsync_n = 1'b1;
        for (int f = 0; f < n; f++) begin
            for (int b = 0; b < FBITS; b++) begin
                bclk = 1'b1;
                repeat (3) @(negedge clk);
                if (mode == 1 && b%8 == 0) chk("R4 no drive", int'(dt_oe), 0);
                if (mode == 2) begin
                    bit on = txon(b/8);
                    if (b%8 == 0) chk("R1 slot drive at slot start", int'(dt_oe), int'(on));
                    if (on) begin
                        logic [7:0] w = wv(tx_k);
                        chk("R2 msb-first bit", int'(dt), int'(w[7 - b%8]));
                        if (b%8 == 7) tx_k++;
                    end
                end
                @(negedge clk);
                bclk = 1'b0;
                if (b == FBITS-1 && f < n-1) fsync_n = 1'b0;
                repeat (4) @(negedge clk);
                fsync_n = 1'b1;
            end
        end
    endtask

    task automatic free_bits(input int n);
        for (int i = 0; i < n; i++) begin
            bclk = 1'b1;
            repeat (3) @(negedge clk);
            if (i%8 == 0) chk("R9 no drive without sync", int'(dt_oe), 0);
            @(negedge clk);
            bclk = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        ntot++; nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", ntot - nfail, ntot);
        $finish;
    end

    initial begin
        int n0;
        rst_n = 1'b0; bclk = 1'b0; fsync_n = 1'b1; tx_en = 1'b0; rx_en = 1'b0;
        cfg_wr = 1'b0; cfg_dir = 1'b0; cfg_idx = '0; cfg_data = '0; rx_ready = 1'b1;
        for (int s = 0; s < NSLOT; s++) if (txon(s)) ntx++;
        repeat (5) @(negedge clk);
        chk("R11 dt_oe in reset", int'(dt_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 dt_oe", int'(dt_oe), 0);
        chk("R11 rx_valid", int'(rx_valid), 0);
        chk("R11 tx_ready", int'(tx_ready), 0);
        chk("R11 tx_underflow", int'(tx_underflow), 0);
        chk("R11 rx_overflow", int'(rx_overflow), 0);

        // R3: cleared maps after reset enable nothing
        tx_en = 1'b1; rx_en = 1'b1; src_on = 1'b1;
        repeat (4) @(negedge clk);
        run_frames(1, 1);
        chk("R3 no capture with cleared map", nwords, 0);
        chk("R3 no underflow with cleared map", int'(tx_underflow), 0);

        // configure while disabled
        tx_en = 1'b0; rx_en = 1'b0;
        for (int i = 0; i < 8; i++) begin
            cfg_write(1'b0, i, txm(i));
            cfg_write(1'b1, i, rxm(i));
        end
        @(negedge clk);
        tx_en = 1'b1; rx_en = 1'b1;
        // R8: these writes must be ignored
        for (int i = 0; i < 8; i++) begin
            cfg_write(1'b0, i, 16'h0000);
            cfg_write(1'b1, i, 16'h0000);
        end
        repeat (4) @(negedge clk);

        sink_chk = 1'b1;
        run_frames(2, 2);
        repeat (4) @(negedge clk);
        sink_chk = 1'b0;
        chk("R8 R10 word count over two frames", nwords, 240);
        chk("R6 no underflow while fed", int'(tx_underflow), 0);
        chk("R7 no overflow while drained", int'(rx_overflow), 0);

        // R6: starve the transmitter
        src_on = 1'b0;
        run_frames(1, 0);
        repeat (4) @(negedge clk);
        chk("R6 underflow flag", int'(tx_underflow), 1);
        chk("R6 starved slot sends zero", last_d, 0);
        chk("R6 last slot", last_s, 119);

        // R7: stop draining
        rx_ready = 1'b0;
        run_frames(1, 0);
        @(negedge clk);
        chk("R7 overflow flag", int'(rx_overflow), 1);
        chk("R7 word pending", int'(rx_valid), 1);
        chk("R7 newest slot kept", int'(rx_slot), 119);
        chk("R7 newest data kept", int'(rx_data), 0);
        rx_ready = 1'b1;
        repeat (3) @(negedge clk);

        // R4: transmit disabled
        tx_en = 1'b0;
        @(negedge clk);
        chk("R4 tx_ready low when disabled", int'(tx_ready), 0);
        run_frames(1, 1);
        repeat (4) @(negedge clk);
        chk("R4 undriven line reads ones", last_d, 8'hFF);
        chk("R5 last received slot", last_s, 119);

        // R9: missing frame sync
        tx_en = 1'b1;
        run_frames(1, 0);
        repeat (4) @(negedge clk);
        n0 = nwords;
        free_bits(FBITS);
        chk("R9 no capture without sync", nwords, n0);
        run_frames(1, 0);
        repeat (4) @(negedge clk);
        chk("R9 resumes after sync", nwords, n0 + 120);
        chk("R7 overflow stays set", int'(rx_overflow), 1);

        $display("%0d/%0d checks passed", ntot - nfail, ntot);
        $finish;
    end
endmodule